// File: doc/BRIEF.md
# Dual-Phase I2C Clock Waveform Generator

This block sets the timing of the SCL line for an I2C master. A prescaler divides the functional clock down to an internal tick. A phase counter then counts ticks to set how long SCL is driven low and how long it is released high. Each phase length is a programmed byte plus a fixed offset of six. The low-time and high-time configuration words each carry two bytes. The lower byte applies to standard and fast operation. The upper byte applies to high-speed operation.

In high-speed operation the master-code portion still runs on the lower bytes through the prescaler. When the bit engine strobes the phase switch, the block moves to the upper bytes at the next point where SCL goes low. From then on it counts straight on the functional clock, with no prescaling. A released SCL that another device holds low (clock stretching) freezes the high phase. The bit engine gets two one-cycle strobes. One marks each falling edge of SCL. The other marks the middle of each high phase, where data is sampled. Protocol sequencing belongs to the bit engine and is not part of this block.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rst` is high or `en` is low, the block is held in reset. From the following cycle `scl_o` is 1 (released), `fall_tick`, `sample_tick` and `hs_active` are 0, and any pending phase switch is discarded.
- R2: The prescaler produces one internal tick every `psc_div`+1 functional clock cycles. It restarts at every phase boundary, so outside high-speed timing every phase lasts a whole number of these periods.
- R3: Outside high-speed timing, each low phase (`scl_o` = 0) lasts (`scl_low_cfg[7:0]` + 6) × (`psc_div` + 1) clock cycles. `scl_low_cfg[15:8]` has no effect on it.
- R4: Outside high-speed timing, each unstretched high phase lasts (`scl_high_cfg[7:0]` + 6) × (`psc_div` + 1) clock cycles. `scl_high_cfg[15:8]` has no effect on it.
- R5: `fall_tick` is high for exactly one cycle: the first cycle in which `scl_o` reads 0 after having been 1.
- R6: `sample_tick` is high for exactly one cycle in each unstretched high phase. Counting the first high cycle as index 0, it is high at index floor(H/2) × T, where H is the high count including the offset of six and T is the tick period in clock cycles.
- R7: While `scl_o` is 1 and `scl_in` reads 0, the high phase is frozen. Each such cycle lengthens the high phase by one clock cycle.
- R8: With `hs_mode` = 1 and no switch taken, timing uses the lower bytes through the prescaler. Once switched, low lasts `scl_low_cfg[15:8]` + 6 cycles and high lasts `scl_high_cfg[15:8]` + 6 cycles of the functional clock, and `psc_div` has no effect.
- R9: A `hs_switch` pulse while `hs_mode` = 1 takes effect only at the next high-to-low transition of `scl_o`. `hs_active` rises in the same cycle as `fall_tick`, and the phase then starting uses high-speed timing.
- R10: While `hs_mode` is 0, `hs_switch` is ignored. Clearing `hs_mode` drops `hs_active` in the next cycle, and standard/fast timing returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; 0 holds the generator in reset |
| hs_mode | input | 1 | High-speed operation selected |
| hs_switch | input | 1 | One-cycle request to move to high-speed timing |
| psc_div | input | PSC_W | Prescaler divisor minus one |
| scl_low_cfg | input | 16 | Low time: [7:0] standard/fast, [15:8] high-speed |
| scl_high_cfg | input | 16 | High time: [7:0] standard/fast, [15:8] high-speed |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| fall_tick | output | 1 | One-cycle strobe in the first low cycle |
| sample_tick | output | 1 | One-cycle strobe in the middle of the high phase |
| hs_active | output | 1 | High-speed timing in effect |

## Verification
Every output comes from a register. A change in configuration or in `scl_in` therefore shows up one edge after the cycle in which it is sampled. Phase lengths are due exactly (count + 6) × (`psc_div` + 1) edges after the boundary edge. The bench samples on the falling clock edge and measures whole runs of `scl_o`, so the exact cycle of a transition is compared with the requirement formula and not with a fixed wall-clock time. `fall_tick` is checked in the first low cycle of a run. `sample_tick` is checked by its index inside the high run. `hs_active` is checked in the last high cycle before a switch can apply and in the first low cycle after it, and one cycle after `hs_mode` is cleared.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    // Width of one timing byte and of a phase count including the offset.
    localparam int SCL_BYTE_W = 8;
    localparam int SCL_CFG_W  = 2 * SCL_BYTE_W;
    localparam int SCL_LIM_W  = SCL_BYTE_W + 1;
    localparam int SCL_OFS    = 6;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Phase lengths in ticks plus the tick source for the active speed.
    typedef struct packed {
        logic [SCL_LIM_W-1:0] lo_lim;
        logic [SCL_LIM_W-1:0] hi_lim;
        logic                 bypass;
    } scl_timing_t;

    function automatic logic [SCL_LIM_W-1:0] phase_limit(input logic [SCL_BYTE_W-1:0] b);
        return SCL_LIM_W'(b) + SCL_LIM_W'(SCL_OFS);
    endfunction

endpackage

// File: rtl/i2c_scl_presc.sv
module i2c_scl_presc #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             bypass,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pc;

    assign tick = !hold && (bypass || (pc == div));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (hold) begin
            pc <= pc;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + PSC_W'(1);
        end
    end

    AST_HOLD_FREEZES_PRESC: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc)); // R7

endmodule

// File: rtl/i2c_scl_phase_ctr.sv
module i2c_scl_phase_ctr #(
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [LIM_W-1:0] lim,
    output logic             done,
    output logic [LIM_W-1:0] cnt
);
    localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

    // Greater-or-equal keeps a phase from overrunning if the limit shrinks.
    assign done = tick && ((cnt + ONE) >= lim);

    always_ff @(posedge clk) begin
        if (rst || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + ONE;
        end
    end

    AST_DONE_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |=> (cnt == '0)); // R3

endmodule

// File: rtl/i2c_scl_hs_sel.sv
module i2c_scl_hs_sel
    import i2c_scl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hs_mode,
    input  logic                 hs_switch,
    input  logic                 going_low,
    input  logic [SCL_CFG_W-1:0] low_cfg,
    input  logic [SCL_CFG_W-1:0] high_cfg,
    output logic                 hs_active,
    output scl_timing_t          timing
);
    logic pend;
    logic act;

    always_ff @(posedge clk) begin
        if (rst || !hs_mode) begin
            pend <= 1'b0;
            act  <= 1'b0;
        end else if (going_low && (pend || hs_switch)) begin
            pend <= 1'b0;
            act  <= 1'b1;
        end else if (hs_switch) begin
            pend <= 1'b1;
        end
    end

    always_comb begin
        if (act) begin
            timing.lo_lim = phase_limit(low_cfg[SCL_CFG_W-1:SCL_BYTE_W]);
            timing.hi_lim = phase_limit(high_cfg[SCL_CFG_W-1:SCL_BYTE_W]);
        end else begin
            timing.lo_lim = phase_limit(low_cfg[SCL_BYTE_W-1:0]);
            timing.hi_lim = phase_limit(high_cfg[SCL_BYTE_W-1:0]);
        end
        timing.bypass = act;
    end

    assign hs_active = act;

    AST_MODE_OFF_DROPS_HS: assert property (@(posedge clk) disable iff (rst)
        !hs_mode |=> !hs_active); // R10

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 hs_mode,
    input  logic                 hs_switch,
    input  logic [PSC_W-1:0]     psc_div,
    input  logic [SCL_CFG_W-1:0] scl_low_cfg,
    input  logic [SCL_CFG_W-1:0] scl_high_cfg,
    input  logic                 scl_in,
    output logic                 scl_o,
    output logic                 fall_tick,
    output logic                 sample_tick,
    output logic                 hs_active
);
    localparam logic [SCL_LIM_W-1:0] ONE = SCL_LIM_W'(1);

    logic                 core_rst;
    scl_phase_e           phase;
    scl_timing_t          timing;
    logic [SCL_LIM_W-1:0] lim;
    logic [SCL_LIM_W-1:0] half;
    logic [SCL_LIM_W-1:0] cnt;
    logic                 tick;
    logic                 done;
    logic                 stretch;
    logic                 going_low;
    logic                 fall_q;
    logic                 samp_q;

    assign core_rst  = rst || !en;
    assign stretch   = (phase == PH_HIGH) && !scl_in;
    assign lim       = (phase == PH_HIGH) ? timing.hi_lim : timing.lo_lim;
    assign half      = {1'b0, lim[SCL_LIM_W-1:1]};
    assign going_low = done && (phase == PH_HIGH);

    i2c_scl_hs_sel u_sel (
        .clk       (clk),
        .rst       (core_rst),
        .hs_mode   (hs_mode),
        .hs_switch (hs_switch),
        .going_low (going_low),
        .low_cfg   (scl_low_cfg),
        .high_cfg  (scl_high_cfg),
        .hs_active (hs_active),
        .timing    (timing)
    );

    i2c_scl_presc #(.PSC_W(PSC_W)) u_presc (
        .clk    (clk),
        .rst    (core_rst),
        .hold   (stretch),
        .bypass (timing.bypass),
        .div    (psc_div),
        .tick   (tick)
    );

    i2c_scl_phase_ctr #(.LIM_W(SCL_LIM_W)) u_ctr (
        .clk  (clk),
        .rst  (core_rst),
        .tick (tick),
        .lim  (lim),
        .done (done),
        .cnt  (cnt)
    );

    always_ff @(posedge clk) begin
        if (core_rst) begin
            phase  <= PH_HIGH;
            fall_q <= 1'b0;
            samp_q <= 1'b0;
        end else begin
            if (done) begin
                phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
            end
            fall_q <= going_low;
            samp_q <= (phase == PH_HIGH) && tick && ((cnt + ONE) == half);
        end
    end

    assign scl_o       = (phase == PH_HIGH);
    assign fall_tick   = fall_q;
    assign sample_tick = samp_q;

    AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl_o && !fall_tick && !sample_tick && !hs_active)); // R1
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !fall_tick); // R5
    AST_FALL_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        fall_tick |-> (!scl_o && $past(scl_o))); // R5
    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> scl_o); // R6
    AST_STRETCH_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (en && scl_o && !scl_in) |=> scl_o); // R7
    AST_HS_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_active) |-> fall_tick); // R9

endmodule

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;

    typedef struct packed {
        logic [7:0]  psc;
        logic [15:0] lo_cfg;
        logic [15:0] hi_cfg;
        int          exp_lo;
        int          exp_hi;
        int          exp_samp;
    } vec_t;

    // Expected runs: (byte+6)*(psc+1); sample index floor((hi byte+6)/2)*(psc+1).
    localparam vec_t VECS[4] = '{
        '{8'd0, 16'h0000, 16'h0000,   6,   6,   3},
        '{8'd1, 16'h0002, 16'h0005,  16,  22,  10},
        '{8'd2, 16'hFF04, 16'hAA03,  30,  27,  12},
        '{8'd0, 16'h00FF, 16'h00FE, 261, 260, 130}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        hs_mode = 1'b0;
    logic        hs_switch = 1'b0;
    logic [7:0]  psc_div = 8'd0;
    logic [15:0] scl_low_cfg = 16'd0;
    logic [15:0] scl_high_cfg = 16'd0;
    logic        stretch_force = 1'b0;
    logic        scl_in;
    logic        scl_o;
    logic        fall_tick;
    logic        sample_tick;
    logic        hs_active;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    assign scl_in = scl_o & ~stretch_force;

    i2c_scl_gen dut (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .hs_mode      (hs_mode),
        .hs_switch    (hs_switch),
        .psc_div      (psc_div),
        .scl_low_cfg  (scl_low_cfg),
        .scl_high_cfg (scl_high_cfg),
        .scl_in       (scl_in),
        .scl_o        (scl_o),
        .fall_tick    (fall_tick),
        .sample_tick  (sample_tick),
        .hs_active    (hs_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl);
        while (scl_o !== lvl) @(negedge clk);
    endtask

    // Called in the first low cycle; returns in the first low cycle of the next bit.
    task automatic measure(input int st_at, input int st_len,
                           output int lo, output int hi, output int sidx, output bit fall_seen);
        lo = 0; hi = 0; sidx = -1;
        fall_seen = fall_tick;
        while (scl_o === 1'b0) begin
            lo++;
            @(negedge clk);
        end
        while (scl_o === 1'b1) begin
            if (sample_tick && sidx < 0) sidx = hi;
            stretch_force = (hi >= st_at) && (hi < st_at + st_len);
            hi++;
            @(negedge clk);
        end
        stretch_force = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int lo, hi, sidx;
        bit fs;
        bit stayed;

        // Reset state (R1)
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(scl_o === 1'b1 && fall_tick === 1'b0 && sample_tick === 1'b0 && hs_active === 1'b0,
              "R1 reset state", int'(scl_o), 1);
        rst = 1'b0;
        en  = 1'b0;
        @(negedge clk);

        // Table of standard/fast configurations (R2 R3 R4 R5 R6)
        for (int i = 0; i < 4; i++) begin
            en = 1'b0;
            psc_div      = VECS[i].psc;
            scl_low_cfg  = VECS[i].lo_cfg;
            scl_high_cfg = VECS[i].hi_cfg;
            @(negedge clk);
            en = 1'b1;
            wait_level(1'b0);
            measure(-1, 0, lo, hi, sidx, fs);
            check(fs == 1'b1, "R5 fall strobe in first low cycle", int'(fs), 1);
            check(lo == VECS[i].exp_lo, "R3 R2 low length", lo, VECS[i].exp_lo);
            check(hi == VECS[i].exp_hi, "R4 R2 high length", hi, VECS[i].exp_hi);
            check(sidx == VECS[i].exp_samp, "R6 sample index", sidx, VECS[i].exp_samp);
        end

        // Clock stretching: 7 held cycles add 7 cycles (R7)
        en = 1'b0;
        psc_div = 8'd1; scl_low_cfg = 16'h0002; scl_high_cfg = 16'h0005;
        @(negedge clk);
        en = 1'b1;
        wait_level(1'b0);
        measure(3, 7, lo, hi, sidx, fs);
        check(hi == 29, "R7 stretched high length", hi, 29);
        check(lo == 16, "R7 low unaffected by stretch", lo, 16);

        // Disable mid-run (R1)
        en = 1'b0;
        @(negedge clk);
        check(scl_o === 1'b1 && fall_tick === 1'b0 && sample_tick === 1'b0,
              "R1 disable releases line", int'(scl_o), 1);
        stayed = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || fall_tick !== 1'b0) stayed = 1'b0;
        end
        check(stayed, "R1 held released while disabled", int'(stayed), 1);

        // High-speed sequence (R8 R9 R10)
        psc_div = 8'd3; scl_low_cfg = 16'h0402; scl_high_cfg = 16'h0301;
        hs_mode = 1'b1;
        en = 1'b1;
        wait_level(1'b0);
        measure(-1, 0, lo, hi, sidx, fs);
        check(lo == 32 && hi == 28, "R8 master-code phase on lower bytes", lo * 1000 + hi, 32028);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        wait_level(1'b1);
        check(hs_active === 1'b0, "R9 no switch before low boundary", int'(hs_active), 0);
        while (scl_o === 1'b1) begin
            check(hs_active === 1'b0, "R9 no switch during high", int'(hs_active), 0);
            @(negedge clk);
        end
        check(hs_active === 1'b1 && fall_tick === 1'b1, "R9 switch at falling edge",
              int'(hs_active), 1);
        measure(-1, 0, lo, hi, sidx, fs);
        check(lo == 10, "R8 high-speed low length", lo, 10);
        check(hi == 9, "R8 high-speed high length", hi, 9);
        hs_mode = 1'b0;
        @(negedge clk);
        check(hs_active === 1'b0, "R10 mode clear drops high speed", int'(hs_active), 0);
        wait_level(1'b1);
        wait_level(1'b0);
        measure(-1, 0, lo, hi, sidx, fs);
        check(lo == 32 && hi == 28, "R10 standard timing restored", lo * 1000 + hi, 32028);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        wait_level(1'b1);
        wait_level(1'b0);
        check(hs_active === 1'b0, "R10 switch ignored without mode", int'(hs_active), 0);
        measure(-1, 0, lo, hi, sidx, fs);
        check(lo == 32, "R10 timing unchanged after ignored switch", lo, 32);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule